// File: doc/BRIEF.md
# Bit-Serial Adder Accumulator

This block adds two unsigned WIDTH-bit operands using a single full adder, stepping through one bit pair per clock. Two right-shifting registers hold the operands. The accumulator register (A) holds the augend, and the operand register (B) holds the addend. Each clock, the full adder combines the two least significant bits with the stored carry. The sum bit enters A at its top and the carry-out is kept for the next bit. After WIDTH shifts, A holds the sum.

While B feeds its bits to the adder, its vacated upper end is refilled from a serial input. The next operand can therefore be streamed in during the current addition. An accumulate pass then adds that operand to the sum already in A without any parallel reload, which builds a running total over any number of passes. A pass is launched by a start strobe. `busy_o` covers the pass, and a single-cycle `done_o` marks its end. The final carry-out of a pass is held in `carry_o` until the next pass completes.

Top module: `bit_serial_accum`

## Requirements
- R1: A synchronous active-high reset clears A, B, the running carry and the bit counter. It also drives `busy_o`, `done_o` and `carry_o` low. A reset during a pass abandons the pass.
- R2: A start accepted with `accum_i`=0 loads A from `a_load_i` and B from `b_load_i` and clears the running carry. After the pass, `acc_o` = (a + b) mod 2^WIDTH and `carry_o` = bit WIDTH of a + b.
- R3: `busy_o` rises in the cycle after an accepted start and stays high for exactly WIDTH cycles.
- R4: `done_o` is high for exactly one cycle, in the cycle after the WIDTH-th shift, and `busy_o` is low in that cycle.
- R5: On each busy clock, the new top bit of A is the full-adder sum of the least significant bits of A and B and the running carry. Bits are therefore added least significant first.
- R6: On each busy clock, `ser_i` enters the top of B. The bit presented on the first shift ends up as bit 0 of B after the pass.
- R7: A start accepted with `accum_i`=1 keeps A and B unchanged and clears the running carry. After the pass, `acc_o` = (A + B) mod 2^WIDTH and `carry_o` = the carry-out of that sum.
- R8: A start strobe while `busy_o` is high is ignored. The running pass finishes on time with an unchanged result.
- R9: `carry_o` holds its value between passes. The running carry is cleared at the end of each pass, so a later pass does not see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a pass; ignored while busy |
| accum_i | input | 1 | Pass kind at start: 0 loads both operands, 1 accumulates |
| a_load_i | input | WIDTH | Augend loaded into A on a load start |
| b_load_i | input | WIDTH | Addend loaded into B on a load start |
| ser_i | input | 1 | Serial bit shifted into the top of B on each busy clock |
| busy_o | output | 1 | High for the WIDTH cycles of a pass |
| done_o | output | 1 | One-cycle pulse after the last shift |
| acc_o | output | WIDTH | Contents of register A |
| carry_o | output | 1 | Final carry-out of the most recent pass |

## Verification
The bound checker enforces the per-cycle rules on every clock: the full-adder bit written into the top of A, the exact busy length counted against `done_o`, the single-cycle done pulse, A and B held across an accumulate start, and a running carry of zero when a pass begins. The bench scenarios cover the rest. These are the arithmetic results of whole passes against a bench model of plain addition, chains of streamed accumulate passes, the all-ones carry corners, a start strobe during a pass, `carry_o` holding between passes, and a reset that abandons a pass.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef struct packed {
    logic sum;
    logic cout;
  } fa_t;

  function automatic fa_t full_add(input logic x, input logic y, input logic ci);
    fa_t r;
    r.sum  = x ^ y ^ ci;
    r.cout = (x & y) | (x & ci) | (y & ci);
    return r;
  endfunction
endpackage

// File: rtl/bsa_shift_reg.sv
module bsa_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         top_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {top_in, q[W-1:1]};
  end
endmodule

// File: rtl/bsa_carry_unit.sv
module bsa_carry_unit (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic x_bit,
  input  logic y_bit,
  output logic sum_bit,
  output logic cout,
  output logic c_q
);
  import bsa_pkg::*;
  fa_t fa;

  always_comb begin
    fa      = full_add(x_bit, y_bit, c_q);
    sum_bit = fa.sum;
    cout    = fa.cout;
  end

  // clear wins over capture, so the final carry of a pass is dropped here
  always_ff @(posedge clk) begin
    if (rst || clr) c_q <= 1'b0;
    else if (step)  c_q <= fa.cout;
  end
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy,
  output logic start_ok,
  output logic last_shift,
  output logic done
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  assign start_ok   = start_i & ~busy;
  assign last_shift = busy & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last_shift;
      if (start_ok) begin
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last_shift) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bit_serial_accum.sv
module bit_serial_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         accum_i,
  input  logic [W-1:0] a_load_i,
  input  logic [W-1:0] b_load_i,
  input  logic         ser_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] acc_o,
  output logic         carry_o
);
  // named internal events, visible to the bound checker
  logic         start_ok;
  logic         last_shift;
  logic         load_ops;
  logic         sum_bit;
  logic         cout;
  logic         carry_q;
  logic [W-1:0] b_q;

  assign load_ops = start_ok & ~accum_i;

  bsa_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .busy(busy_o), .start_ok(start_ok), .last_shift(last_shift), .done(done_o)
  );

  bsa_shift_reg #(.W(W)) u_reg_a (
    .clk(clk), .rst(rst), .load_en(load_ops), .load_val(a_load_i),
    .shift_en(busy_o), .top_in(sum_bit), .q(acc_o)
  );

  bsa_shift_reg #(.W(W)) u_reg_b (
    .clk(clk), .rst(rst), .load_en(load_ops), .load_val(b_load_i),
    .shift_en(busy_o), .top_in(ser_i), .q(b_q)
  );

  bsa_carry_unit u_carry (
    .clk(clk), .rst(rst), .clr(start_ok | last_shift), .step(busy_o),
    .x_bit(acc_o[0]), .y_bit(b_q[0]),
    .sum_bit(sum_bit), .cout(cout), .c_q(carry_q)
  );

  always_ff @(posedge clk) begin
    if (rst)             carry_o <= 1'b0;
    else if (last_shift) carry_o <= cout;
  end
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         accum_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] b_q,
  input logic         carry_q
);
  localparam int BW = $clog2(W + 1) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)         bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1'b1;
    else             bcnt <= '0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (bcnt < BW'(W)));

  // R4
  done_after_n_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && bcnt == BW'(W)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  sum_bit_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> acc_o[W-1] == $past(bsa_pkg::full_add(acc_o[0], b_q[0], carry_q).sum));

  // R7
  accum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && accum_i && !busy_o) |=> (acc_o == $past(acc_o) && b_q == $past(b_q)));

  // R2
  carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !carry_q);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && bcnt < BW'(W - 1)) |=> busy_o);
endmodule

bind bit_serial_accum bsa_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .accum_i(accum_i),
  .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o), .b_q(b_q), .carry_q(carry_q)
);

// File: tb/bit_serial_accum_tb.sv
module bit_serial_accum_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         accum_i = 1'b0;
  logic [W-1:0] a_load_i = '0;
  logic [W-1:0] b_load_i = '0;
  logic         ser_i = 1'b0;
  logic         busy_o, done_o, carry_o;
  logic [W-1:0] acc_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // bench model state
  logic [W-1:0] m_a, m_b;
  logic         m_c;

  always #5 clk = ~clk;

  bit_serial_accum #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .accum_i(accum_i),
    .a_load_i(a_load_i), .b_load_i(b_load_i), .ser_i(ser_i),
    .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o), .carry_o(carry_o)
  );

  function automatic logic [W:0] model_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // one pass; inject_start raises start_i mid pass with other operands
  task automatic run_pass(input logic mode, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] stream, input bit inject_start);
    logic [W:0] s;
    @(negedge clk);
    start_i = 1'b1; accum_i = mode; a_load_i = a; b_load_i = b;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R3 busy after start", busy_o, 1);
    if (mode == 1'b0) begin m_a = a; m_b = b; end
    s = model_add(m_a, m_b);
    for (int i = 0; i < W; i++) begin
      ser_i = stream[i];
      if (inject_start && i == 2) begin
        start_i = 1'b1; accum_i = 1'b0; a_load_i = ~a; b_load_i = ~b;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      if (i < W - 1) begin
        if (busy_o !== 1'b1 || done_o !== 1'b0) check("R3 busy held during pass", {busy_o, done_o}, 2'b10);
      end
    end
    start_i = 1'b0;
    m_a = s[W-1:0]; m_c = s[W]; m_b = stream;
    check("R4 done pulse at end", {busy_o, done_o}, 2'b01);
    check(mode ? "R7 accumulate sum" : "R2 load sum", acc_o, m_a);
    check(mode ? "R7 accumulate carry" : "R2 load carry", carry_o, m_c);
    @(negedge clk);
    check("R4 done one cycle", done_o, 0);
    check("R9 carry held", carry_o, m_c);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_a = '0; m_b = '0; m_c = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy_o, 0);
    check("R1 reset done", done_o, 0);
    check("R1 reset acc", acc_o, 0);
    check("R1 reset carry", carry_o, 0);
    rst = 1'b0;

    // R2 corners
    run_pass(1'b0, 8'h00, 8'h00, 8'h00, 1'b0);
    run_pass(1'b0, 8'hFF, 8'h01, 8'h00, 1'b0);
    run_pass(1'b0, 8'hFF, 8'hFF, 8'h01, 1'b0);
    // R9: running carry must not leak into this pass (B holds 0x01)
    run_pass(1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 carry held idle", carry_o, m_c);
    // R6 / R7: streamed operands accumulated
    run_pass(1'b0, 8'h10, 8'h20, 8'h81, 1'b0);
    run_pass(1'b1, 8'h00, 8'h00, 8'h7F, 1'b0);
    run_pass(1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
    // R8: start during a pass ignored
    run_pass(1'b0, 8'h5A, 8'hC3, 8'h11, 1'b1);
    run_pass(1'b1, 8'h00, 8'h00, 8'h22, 1'b1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic md;
      md = ($urandom % 3) != 0;
      run_pass(md, W'($urandom), W'($urandom), W'($urandom), ($urandom % 5) == 0);
      repeat ($urandom % 3) @(negedge clk);
    end

    // R1: reset in the middle of a pass
    @(negedge clk);
    start_i = 1'b1; accum_i = 1'b0; a_load_i = 8'hAB; b_load_i = 8'hCD;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-pass reset busy", busy_o, 0);
    check("R1 mid-pass reset acc", acc_o, 0);
    check("R1 mid-pass reset carry", carry_o, 0);
    m_a = '0; m_b = '0; m_c = 1'b0;
    // R1: B was cleared, so the sum stays 0 while 0x3C is streamed in
    run_pass(1'b1, 8'h00, 8'h00, 8'h3C, 1'b0);
    run_pass(1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
    check("R6 streamed operand reached A", acc_o, 8'h3C);

    finished = 1'b1;
    summary();
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        summary();
      end
    end
  end
endmodule